// File: doc/BRIEF.md
# Thirty-two input interrupt controller

This block gathers 32 interrupt source lines into one request for the processor core. Each line feeds a status bit. Enable bits mask the status bits. The OR of all enabled status bits drives `irq_o`. The core masks this request with its own external-interrupt enable. Software acknowledges an interrupt by writing ones to the status register.

The lines fall into three groups. Lines 0 to 18 are fixed sources, sensed active-high and level-sensitive. Lines 19 to 24 are reserved and never raise status. Lines 25 to 31 are programmable: software picks the sense (high or low) and the trigger mode (level or edge) for each line.

Every line passes through a two-flop synchroniser before its status logic. A small register bus gives access to the status, enable, polarity and trigger registers, plus a read-only register that reports the lowest-numbered line that is both pending and enabled. The bus logic is a two-state machine: `BUS_IDLE` waits for a request. A read request moves it to `BUS_READ`, which presents the read data with `bus_rvalid` for one cycle and then always returns to `BUS_IDLE`. A write is taken in either state at the clock edge where it is requested and does not change state.

Top module: `irq_hub`

## Requirements
- R1: After reset, status, enable and trigger all read 0. Polarity reads 0xFE000000 (lines 25-31 active-high). The pending-number register reads 32 and `irq_o` is 0.
- R2: For lines 0-18, the status bit equals the raw input three clock edges earlier (active-high, level). Writes to those bits of the polarity and trigger registers are ignored, and those bits read 0.
- R3: Lines 19-24 always read 0 in the status register, whatever their inputs do. Their enable bits ignore writes and read 0.
- R4: For lines 25-31, polarity bit 1 selects active-high and polarity bit 0 selects active-low. In level mode (trigger bit 0) the status bit tracks the input after polarity correction.
- R5: For lines 25-31 with trigger bit 1 (edge mode), a change of the corrected input from inactive to active sets the status bit. The bit stays set after the input returns inactive, until software writes 1 to that status bit.
- R6: Writing 1 to a status bit of a level-mode line has no lasting effect while the line is still active. Writing 0 to any status bit has no effect.
- R7: `irq_o` is 1 exactly when some status bit and its enable bit are both 1.
- R8: The register at offset 4 returns, in bits 5:0, the lowest line number whose status and enable bits are both 1, or 32 when there is none. All its other bits read 0.
- R9: A read at offset 0 (status), 1 (enable), 2 (polarity), 3 (trigger) or 4 (pending number) returns the data with `bus_rvalid` high on the edge after the request, for exactly one cycle. Offsets 5-7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access request, one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid pulse |
| src_i | input | 32 | Raw interrupt source lines |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The bench drives the reserved lines high and also writes their enable bits. A design that let either through would show status bits or raise `irq_o`. It tries to acknowledge a fixed level line that is still high: a design that kept the clear would lose an interrupt that is still being requested. It drops an edge-mode line before software clears it: a design that tracked the level would lose the bit before software saw it. It also inverts a programmable line and checks the pending number as enables are removed one by one, which catches a wrong polarity sense and a search that finds the highest line instead of the lowest.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_READ = 1'b1
    } bus_state_t;

    localparam logic [2:0] OFS_STAT = 3'd0;
    localparam logic [2:0] OFS_EN   = 3'd1;
    localparam logic [2:0] OFS_POL  = 3'd2;
    localparam logic [2:0] OFS_TRIG = 3'd3;
    localparam logic [2:0] OFS_PEND = 3'd4;

    function automatic logic [31:0] span_mask(input int lo, input int hi);
        logic [31:0] m;
        m = '0;
        for (int k = 0; k < 32; k++) begin
            if (k >= lo && k <= hi) m[k] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_hub_sync.sv
module irq_hub_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/irq_hub_cell.sv
module irq_hub_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic live_i,
    input  logic pol_i,
    input  logic edge_i,
    input  logic clr_i,
    output logic stat_o
);
    logic active;
    logic active_prev_q;
    logic rise;

    assign active = live_i & (pol_i ? line_i : ~line_i);
    assign rise   = active & ~active_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_prev_q <= 1'b0;
            stat_o        <= 1'b0;
        end else begin
            active_prev_q <= active;
            if (edge_i) stat_o <= rise | (stat_o & ~clr_i);
            else        stat_o <= active;
        end
    end
endmodule

// File: rtl/irq_hub_lowest.sv
module irq_hub_lowest #(
    parameter int N   = 32,
    localparam int IW = $clog2(N) + 1
) (
    input  logic [N-1:0]  vec_i,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = IW'(N);
        for (int k = N - 1; k >= 0; k--) begin
            if (vec_i[k]) idx_o = IW'(k);
        end
    end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int N_SRC      = 32,
    parameter int FIXED_LAST = 18,
    parameter int RSVD_LAST  = 24,
    localparam int IW        = $clog2(N_SRC) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_rvalid,
    input  logic [31:0] src_i,
    output logic        irq_o
);
    localparam logic [31:0] PROG_MASK = span_mask(RSVD_LAST + 1, N_SRC - 1);
    localparam logic [31:0] RSVD_MASK = span_mask(FIXED_LAST + 1, RSVD_LAST);
    localparam logic [31:0] LIVE_MASK = span_mask(0, N_SRC - 1) & ~RSVD_MASK;

    bus_state_t  state_q, state_d;
    logic [31:0] stat_q, en_q, pol_q, trig_q;
    logic [31:0] line_s, clr_vec, rd_mux;
    logic [IW-1:0] pend_id;
    logic        wr_hit, rd_hit;

    assign wr_hit  = bus_req & bus_we;
    assign rd_hit  = bus_req & ~bus_we & (state_q == BUS_IDLE);
    assign clr_vec = (wr_hit && bus_addr == OFS_STAT) ? bus_wdata : '0;

    irq_hub_sync #(.WIDTH(32)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(line_s)
    );

    for (genvar i = 0; i < 32; i++) begin : g_src
        if (i <= FIXED_LAST) begin : g_fixed
            irq_hub_cell u_cell (
                .clk(clk), .rst_n(rst_n), .line_i(line_s[i]), .live_i(1'b1),
                .pol_i(1'b1), .edge_i(1'b0), .clr_i(clr_vec[i]), .stat_o(stat_q[i])
            );
        end else if (i <= RSVD_LAST) begin : g_rsvd
            irq_hub_cell u_cell (
                .clk(clk), .rst_n(rst_n), .line_i(line_s[i]), .live_i(1'b0),
                .pol_i(1'b1), .edge_i(1'b0), .clr_i(clr_vec[i]), .stat_o(stat_q[i])
            );
        end else begin : g_prog
            irq_hub_cell u_cell (
                .clk(clk), .rst_n(rst_n), .line_i(line_s[i]), .live_i(1'b1),
                .pol_i(pol_q[i]), .edge_i(trig_q[i]), .clr_i(clr_vec[i]),
                .stat_o(stat_q[i])
            );
        end
    end

    irq_hub_lowest #(.N(32)) u_lowest (
        .vec_i(stat_q & en_q), .idx_o(pend_id)
    );

    assign irq_o = |(stat_q & en_q);

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            pol_q  <= PROG_MASK;
            trig_q <= '0;
        end else if (wr_hit) begin
            unique case (bus_addr)
                OFS_EN:   en_q   <= bus_wdata & LIVE_MASK;
                OFS_POL:  pol_q  <= bus_wdata & PROG_MASK;
                OFS_TRIG: trig_q <= bus_wdata & PROG_MASK;
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_STAT: rd_mux = stat_q;
            OFS_EN:   rd_mux = en_q;
            OFS_POL:  rd_mux = pol_q;
            OFS_TRIG: rd_mux = trig_q;
            OFS_PEND: rd_mux = 32'(pend_id);
            default:  rd_mux = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd_hit) state_d = BUS_READ;
            BUS_READ: state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else if (rd_hit) bus_rdata <= rd_mux;
    end

    assign bus_rvalid = (state_q == BUS_READ);

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
    parameter int N_SRC = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] src_i,
    input logic [31:0] stat,
    input logic [31:0] trig,
    input logic [31:0] clr_vec,
    input logic        irq_o,
    input logic [5:0]  pend_id,
    input logic        rvalid
);
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stat[24:19] == 6'd0); // R3

    AST_FIXED_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (stat[18:0] == $past(src_i[18:0], 3))); // R2

    AST_IRQ_HAS_ID: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_id != 6'(N_SRC))); // R8

    AST_NO_IRQ_NO_ID: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (pend_id == 6'(N_SRC))); // R7

    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid); // R9

    for (genvar i = 25; i < 32; i++) begin : g_sticky
        AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(trig[i]) && $fell(stat[i])) |-> $past(clr_vec[i])); // R5
    end
endmodule

bind irq_hub irq_hub_chk #(.N_SRC(N_SRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .stat(stat_q), .trig(trig_q),
    .clr_vec(clr_vec), .irq_o(irq_o), .pend_id(pend_id), .rvalid(bus_rvalid)
);

// File: tb/irq_hub_tb.sv
module irq_hub_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [31:0] src_i = '0;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_hub u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .src_i(src_i), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_req = 1'b0;
        check("R9 rvalid", 32'(bus_rvalid), 32'd1);
        d = bus_rdata;
        @(posedge clk); #1;
        check("R9 rvalid drop", 32'(bus_rvalid), 32'd0);
    endtask

    task automatic drive_src(input logic [31:0] v);
        @(posedge clk); #1;
        src_i = v;
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", 32'(irq_o), 32'd0);
        reg_rd(3'd0, d); check("R1 status", d, 32'h0);
        reg_rd(3'd1, d); check("R1 enable", d, 32'h0);
        reg_rd(3'd2, d); check("R1 polarity", d, 32'hFE00_0000);
        reg_rd(3'd3, d); check("R1 trigger", d, 32'h0);
        reg_rd(3'd4, d); check("R1 pending", d, 32'd32);
    endtask

    task automatic t_fixed();
        logic [31:0] d;
        drive_src(32'h0004_0009);
        reg_rd(3'd0, d); check("R2 fixed high", d, 32'h0004_0009);
        reg_wr(3'd2, 32'hFFFF_FFFF);
        reg_wr(3'd3, 32'h0000_0001);
        reg_rd(3'd2, d); check("R2 pol low bits", d, 32'hFE00_0000);
        reg_rd(3'd3, d); check("R2 trig low bits", d, 32'h0);
        drive_src(32'h0000_0000);
        reg_rd(3'd0, d); check("R2 fixed low", d, 32'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        drive_src(32'h01F8_0000);
        reg_rd(3'd0, d); check("R3 status", d, 32'h0);
        reg_wr(3'd1, 32'hFFFF_FFFF);
        reg_rd(3'd1, d); check("R3 enable", d, 32'hFE07_FFFF);
        check("R3 irq", 32'(irq_o), 32'd0);
        reg_wr(3'd1, 32'h0);
        drive_src(32'h0);
    endtask

    task automatic t_polarity();
        logic [31:0] d;
        reg_wr(3'd2, 32'hFC00_0000);
        repeat (3) @(posedge clk);
        #1;
        reg_rd(3'd0, d); check("R4 active-low idle", d, 32'h0200_0000);
        drive_src(32'h0200_0000);
        reg_rd(3'd0, d); check("R4 active-low driven", d, 32'h0);
        drive_src(32'h0);
        reg_wr(3'd2, 32'hFE00_0000);
        repeat (3) @(posedge clk);
        #1;
        reg_rd(3'd0, d); check("R4 restored", d, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        reg_wr(3'd3, 32'h0400_0000);
        drive_src(32'h0400_0000);
        reg_rd(3'd0, d); check("R5 edge set", d, 32'h0400_0000);
        drive_src(32'h0);
        reg_rd(3'd0, d); check("R5 sticky", d, 32'h0400_0000);
        reg_wr(3'd0, 32'h0);
        reg_rd(3'd0, d); check("R6 zero write", d, 32'h0400_0000);
        reg_wr(3'd0, 32'h0400_0000);
        reg_rd(3'd0, d); check("R5 cleared", d, 32'h0);
        reg_wr(3'd3, 32'h0);
    endtask

    task automatic t_level_ack();
        logic [31:0] d;
        drive_src(32'h0000_0001);
        reg_wr(3'd0, 32'h0000_0001);
        reg_rd(3'd0, d); check("R6 level ack", d, 32'h0000_0001);
        drive_src(32'h0);
    endtask

    task automatic t_mask_pend();
        logic [31:0] d;
        drive_src(32'h4000_0024);
        check("R7 masked", 32'(irq_o), 32'd0);
        reg_rd(3'd4, d); check("R8 none", d, 32'd32);
        reg_wr(3'd1, 32'h4000_0024);
        #1; check("R7 enabled", 32'(irq_o), 32'd1);
        reg_rd(3'd4, d); check("R8 lowest 2", d, 32'd2);
        reg_wr(3'd1, 32'h4000_0020);
        reg_rd(3'd4, d); check("R8 lowest 5", d, 32'd5);
        reg_wr(3'd1, 32'h4000_0000);
        reg_rd(3'd4, d); check("R8 lowest 30", d, 32'd30);
        reg_wr(3'd1, 32'h0000_0010);
        #1; check("R7 enable without status", 32'(irq_o), 32'd0);
        reg_rd(3'd5, d); check("R9 unused offset", d, 32'h0);
        reg_wr(3'd1, 32'h0);
        drive_src(32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_fixed();
        t_reserved();
        t_polarity();
        t_edge();
        t_level_ack();
        t_mask_pend();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule